// File: doc/BRIEF.md
# Half-Rate Interleaved Pseudo-Random and Word Pattern Generator

This block produces a serial test pattern for link and receiver testing. In sequence mode it emits a maximal-length pseudo-random bit sequence whose register length is chosen at run time. In word mode it repeats a 16-bit user word without end. The sequence register is clocked at half the line rate and moves two full-rate steps on each slow clock. The two bits of each step form rail A (earlier bit) and rail B (later bit). Rail B is then the same maximal-length sequence as rail A, only shifted by half a period. The full-rate line is modelled as a pair of bits per slow clock, with `ser_o[1]` sent first.

A frame-start marker is raised in the bit slot that begins each pattern frame. In sequence mode that is the single 1 bit just before the longest zero run. In word mode it is the first bit of each word repetition. A one-cycle error strobe flips a single line bit so that a receiver's error counter can be tested. Clock synthesis and analog output stages are not part of this block.

Top module: `hrpat_gen`

## Requirements
- R1: While `rst_n` is low, and for the two clocks after it goes high, all outputs read 0.
- R2: The order select chooses the feedback polynomial. Code 0 gives x^7+x^6+1, 1 gives x^15+x^14+1, 2 gives x^17+x^14+1, 3 gives x^20+x^3+1 and 4 gives x^23+x^18+1. The full-rate stream obeys the recurrence of the selected polynomial: new bit = stage n XOR stage k, shifted in at stage 1, and the output is taken from stage n.
- R3: Each clock emits two consecutive sequence bits. When no error is injected, `ser_o[1]` equals `rail_a_o` (the earlier bit) and `ser_o[0]` equals `rail_b_o`.
- R4: For order 7, rail B at slow cycle i equals rail A at slow cycle (i+64) mod 127.
- R5: For order 7, rail A repeats with a period of exactly 127 slow cycles.
- R6: The register is loaded with the start state (only stage n set) on the first sequence-mode cycle after reset, and on the first sequence-mode cycle whose order code differs from the previous one. That cycle's pair is `ser_o`=2'b10 with `sync_o`=2'b10. The register never holds all zeros.
- R7: In sequence mode, a bit of `sync_o` is set exactly when the bit in the same slot is the 1 that comes before n-1 zeros. For order 7 this gives two marks per 127 slow cycles, and at most one bit of `sync_o` is ever set.
- R8: In word mode (`mode_i`=1) the word is sent MSB first, two bits per clock, and repeats every 8 clocks.
- R9: A word load takes effect at once. The pair registered on the clock that samples `word_ld_i` is bits 15 and 14 of the new `word_i`, and the frame restarts from there.
- R10: In word mode, `sync_o` is 2'b10 on the first pair of each word frame and 2'b00 on every other pair.
- R11: When `err_inj_i` is high on a clock, `ser_o[1]` of the pair registered on that clock is inverted. The rails, the marker and all later bits are unchanged.
- R12: The sequence register holds its state while word mode is active. On return to sequence mode with the same order, the sequence resumes where it stopped.
- R13: Order codes 5 to 7 select the order-7 polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 selects sequence mode, 1 selects word mode |
| ord_sel_i | input | 3 | Sequence order code |
| word_i | input | 16 | User word |
| word_ld_i | input | 1 | Word load strobe |
| err_inj_i | input | 1 | Error inject strobe |
| rail_a_o | output | 1 | Half-rate rail A (earlier bit of each pair) |
| rail_b_o | output | 1 | Half-rate rail B (later bit of each pair) |
| ser_o | output | 2 | Full-rate pair; bit 1 is sent first |
| sync_o | output | 2 | Frame-start marker, one flag per bit slot |

## Verification
The property hardest to reach from the ports is the half-period offset between the rails. It only shows over a full sequence period. The bench records rail A and rail B over two periods of the order-7 sequence and compares every rail B sample against rail A 64 cycles ahead, wrapping at 127. A second hard case is the resume after word mode. The bench leaves the sequence in the middle, runs word frames (with a load in the middle of a frame), and then requires the next sequence bits to continue the model where it was paused, with no reseed.

// File: rtl/hrpat_pkg.sv
package hrpat_pkg;

  localparam int MAXN  = 23;
  localparam int LANES = 2;

  typedef enum logic {
    MODE_PRBS = 1'b0,
    MODE_WORD = 1'b1
  } mode_e;

  // top stage (stage n) of the register for a given order code
  function automatic logic [MAXN-1:0] ord_msb(input logic [2:0] sel);
    logic [MAXN-1:0] one;
    one = {{(MAXN-1){1'b0}}, 1'b1};
    case (sel)
      3'd1:    ord_msb = one << 14;
      3'd2:    ord_msb = one << 16;
      3'd3:    ord_msb = one << 19;
      3'd4:    ord_msb = one << 22;
      default: ord_msb = one << 6;
    endcase
  endfunction

  // inner feedback stage (stage k) for a given order code
  function automatic logic [MAXN-1:0] ord_tap(input logic [2:0] sel);
    logic [MAXN-1:0] one;
    one = {{(MAXN-1){1'b0}}, 1'b1};
    case (sel)
      3'd1:    ord_tap = one << 13;
      3'd2:    ord_tap = one << 13;
      3'd3:    ord_tap = one << 2;
      3'd4:    ord_tap = one << 17;
      default: ord_tap = one << 5;
    endcase
  endfunction

endpackage

// File: rtl/hrpat_rst_sync.sv
module hrpat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/hrpat_prbs.sv
module hrpat_prbs
  import hrpat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       ord_sel,
  output logic [LANES-1:0] dat,
  output logic [LANES-1:0] syn,
  output logic [MAXN-1:0]  st_o
);
  logic [MAXN-1:0] st_q, st_d;
  logic [MAXN-1:0] msb, tap, msk, cur;
  logic [2:0]      ord_q;
  logic            armed_q;
  logic            restart;

  always_comb begin
    msb     = ord_msb(ord_sel);
    tap     = ord_tap(ord_sel);
    msk     = (msb << 1) - {{(MAXN-1){1'b0}}, 1'b1};
    restart = !armed_q || (ord_sel != ord_q);
    cur     = restart ? msb : st_q;
    dat     = '0;
    syn     = '0;
    for (int i = 0; i < LANES; i++) begin
      dat[LANES-1-i] = |(cur & msb);
      syn[LANES-1-i] = (cur == msb);
      cur = {cur[MAXN-2:0], ^(cur & (msb | tap))} & msk;
    end
    st_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= {{(MAXN-1){1'b0}}, 1'b1};
      ord_q   <= '0;
      armed_q <= 1'b0;
    end else if (en) begin
      st_q    <= st_d;
      ord_q   <= ord_sel;
      armed_q <= 1'b1;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/hrpat_word.sv
module hrpat_word
  import hrpat_pkg::*;
#(
  parameter int WORDW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld,
  input  logic [WORDW-1:0] word_i,
  output logic [LANES-1:0] dat,
  output logic [LANES-1:0] syn
);
  localparam int FRAMES = WORDW / LANES;
  localparam int PTRW   = $clog2(FRAMES);

  logic [WORDW-1:0] word_q, word_d, ew, sh;
  logic [PTRW-1:0]  ptr_q, ptr_d, ep;

  always_comb begin
    ew  = ld ? word_i : word_q;
    ep  = ld ? '0 : ptr_q;
    sh  = ew << (int'(ep) * LANES);
    dat = sh[WORDW-1 -: LANES];
    syn = (ep == '0) ? {1'b1, {(LANES-1){1'b0}}} : '0;
    word_d = ew;
    if (en) ptr_d = (ep == PTRW'(FRAMES-1)) ? '0 : ep + 1'b1;
    else    ptr_d = ep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (ld)       word_q <= word_d;
      if (ld || en) ptr_q  <= ptr_d;
    end
  end
endmodule

// File: rtl/hrpat_outsel.sv
module hrpat_outsel
  import hrpat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_sel,
  input  logic             err,
  input  logic [LANES-1:0] p_dat,
  input  logic [LANES-1:0] p_syn,
  input  logic [LANES-1:0] w_dat,
  input  logic [LANES-1:0] w_syn,
  output logic             rail_a,
  output logic             rail_b,
  output logic [LANES-1:0] ser,
  output logic [LANES-1:0] sync
);
  logic [LANES-1:0] dat_d, syn_d, ser_d;

  always_comb begin
    dat_d = word_sel ? w_dat : p_dat;
    syn_d = word_sel ? w_syn : p_syn;
    ser_d = dat_d;
    ser_d[LANES-1] = dat_d[LANES-1] ^ err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_a <= 1'b0;
      rail_b <= 1'b0;
      ser    <= '0;
      sync   <= '0;
    end else begin
      rail_a <= dat_d[LANES-1];
      rail_b <= dat_d[0];
      ser    <= ser_d;
      sync   <= syn_d;
    end
  end
endmodule

// File: rtl/hrpat_gen.sv
module hrpat_gen
  import hrpat_pkg::*;
#(
  parameter int WORDW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [2:0]       ord_sel_i,
  input  logic [WORDW-1:0] word_i,
  input  logic             word_ld_i,
  input  logic             err_inj_i,
  output logic             rail_a_o,
  output logic             rail_b_o,
  output logic [1:0]       ser_o,
  output logic [1:0]       sync_o
);
  logic             rst_s;
  logic             word_sel;
  logic [LANES-1:0] p_dat, p_syn, w_dat, w_syn;
  logic [MAXN-1:0]  prbs_st;

  assign word_sel = (mode_i == MODE_WORD);

  hrpat_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  hrpat_prbs u_prbs (
    .clk(clk), .rst_n(rst_s), .en(!word_sel), .ord_sel(ord_sel_i),
    .dat(p_dat), .syn(p_syn), .st_o(prbs_st)
  );

  hrpat_word #(.WORDW(WORDW)) u_word (
    .clk(clk), .rst_n(rst_s), .en(word_sel), .ld(word_ld_i),
    .word_i(word_i), .dat(w_dat), .syn(w_syn)
  );

  hrpat_outsel u_out (
    .clk(clk), .rst_n(rst_s), .word_sel(word_sel), .err(err_inj_i),
    .p_dat(p_dat), .p_syn(p_syn), .w_dat(w_dat), .w_syn(w_syn),
    .rail_a(rail_a_o), .rail_b(rail_b_o), .ser(ser_o), .sync(sync_o)
  );
endmodule

// File: rtl/hrpat_chk.sv
module hrpat_chk
  import hrpat_pkg::*;
#(
  parameter int WORDW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_i,
  input logic [WORDW-1:0] word_i,
  input logic             word_ld_i,
  input logic             err_inj_i,
  input logic             rail_a_o,
  input logic             rail_b_o,
  input logic [1:0]       ser_o,
  input logic [1:0]       sync_o,
  input logic [MAXN-1:0]  st
);
  logic             err_q, mode_q, ld_q;
  logic [WORDW-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      mode_q <= 1'b0;
      ld_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      err_q  <= err_inj_i;
      mode_q <= mode_i;
      ld_q   <= word_ld_i;
      wd_q   <= word_i;
    end
  end

  // R7
  sync_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_o));

  // R6
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);

  // R3
  rail_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_o == {rail_a_o ^ err_q, rail_b_o});

  // R9
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && mode_q && !err_q) |-> (ser_o == wd_q[WORDW-1 -: 2] && sync_o == 2'b10));

  // R7
  sync_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && sync_o != 2'b00) |-> ((sync_o & {rail_a_o, rail_b_o}) == sync_o));
endmodule

bind hrpat_gen hrpat_chk #(.WORDW(WORDW)) u_chk (
  .clk(clk), .rst_n(rst_s), .mode_i(mode_i), .word_i(word_i),
  .word_ld_i(word_ld_i), .err_inj_i(err_inj_i), .rail_a_o(rail_a_o),
  .rail_b_o(rail_b_o), .ser_o(ser_o), .sync_o(sync_o), .st(prbs_st)
);

// File: tb/tb_hrpat_gen.sv
module tb_hrpat_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_i;
  logic [2:0]  ord_sel_i;
  logic [15:0] word_i;
  logic        word_ld_i;
  logic        err_inj_i;
  logic        rail_a_o, rail_b_o;
  logic [1:0]  ser_o, sync_o;

  int total = 0;
  int fails = 0;

  // bench-side models
  logic [22:0] m;
  int          mn, mk;
  logic [2:0]  last_sel;
  logic        m_armed;
  logic [15:0] wq;
  int          wp;

  logic ra [0:253];
  logic rb [0:253];

  hrpat_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ord_sel_i(ord_sel_i),
    .word_i(word_i), .word_ld_i(word_ld_i), .err_inj_i(err_inj_i),
    .rail_a_o(rail_a_o), .rail_b_o(rail_b_o), .ser_o(ser_o), .sync_o(sync_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void sel_nk(input logic [2:0] s, output int n, output int k);
    case (s)
      3'd1: begin n = 15; k = 14; end
      3'd2: begin n = 17; k = 14; end
      3'd3: begin n = 20; k = 3;  end
      3'd4: begin n = 23; k = 18; end
      default: begin n = 7; k = 6; end
    endcase
  endfunction

  task automatic mstep(output logic b, output logic s);
    logic [22:0] top, msk;
    logic fb;
    top = 23'd1 << (mn - 1);
    msk = (mn == 23) ? '1 : ((23'd1 << mn) - 23'd1);
    s  = (m == top);
    b  = m[mn-1];
    fb = m[mn-1] ^ m[mk-1];
    m  = ((m << 1) | {22'd0, fb}) & msk;
  endtask

  // one clock: drive at negedge, sample at the next negedge, compare to model
  task automatic tick(input logic md, input logic ld, input logic [15:0] w,
                      input logic er, input logic [2:0] sel, input string tag);
    logic [1:0] ed, es;
    logic [15:0] ew;
    int ep;
    mode_i = md; word_ld_i = ld; word_i = w; err_inj_i = er; ord_sel_i = sel;
    @(negedge clk);
    ew = ld ? w : wq;
    ep = ld ? 0 : wp;
    if (ld) wq = w;
    if (md) begin
      ed = {ew[15 - 2*ep], ew[14 - 2*ep]};
      es = (ep == 0) ? 2'b10 : 2'b00;
      wp = (ep + 1) % 8;
    end else begin
      if (ld) wp = 0;
      sel_nk(sel, mn, mk);
      if (!m_armed || sel != last_sel) m = 23'd1 << (mn - 1);
      m_armed = 1'b1;
      last_sel = sel;
      mstep(ed[1], es[1]);
      mstep(ed[0], es[0]);
    end
    chk({rail_a_o, rail_b_o} == ed, tag, "rails", {6'd0, rail_a_o, rail_b_o}, {6'd0, ed});
    chk(ser_o == (ed ^ {er, 1'b0}), tag, "ser", {6'd0, ser_o}, {6'd0, ed ^ {er, 1'b0}});
    chk(sync_o == es, tag, "sync", {6'd0, sync_o}, {6'd0, es});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode_i = 0; ord_sel_i = 0; word_i = 0; word_ld_i = 0; err_inj_i = 0;
    m_armed = 0; last_sel = 0; wq = 0; wp = 0; m = 23'd1; mn = 7; mk = 6;
    repeat (3) @(negedge clk);
    chk({rail_a_o, rail_b_o, ser_o, sync_o} == 6'd0, "R1", "in reset",
        {2'd0, rail_a_o, rail_b_o, ser_o, sync_o}, 8'd0);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk({rail_a_o, rail_b_o, ser_o, sync_o} == 6'd0, "R1", "reset release",
          {2'd0, rail_a_o, rail_b_o, ser_o, sync_o}, 8'd0);
    end
  endtask

  // R2 R6 R13: each order, first pair after change is the start state
  task automatic t_orders();
    for (int s = 0; s < 8; s++) begin
      tick(0, 0, 16'h0, 0, 3'(s), "R6");
      for (int c = 0; c < 60; c++)
        tick(0, 0, 16'h0, 0, 3'(s), (s > 4) ? "R13" : "R2");
    end
  endtask

  // R4 R5 R7: half-period rail offset, period and mark count for order 7
  task automatic t_halfframe();
    int nsync;
    tick(0, 0, 16'h0, 0, 3'd4, "R6");
    nsync = 0;
    for (int c = 0; c < 254; c++) begin
      tick(0, 0, 16'h0, 0, 3'd0, (c == 0) ? "R6" : "R7");
      ra[c] = rail_a_o;
      rb[c] = rail_b_o;
      if (c < 127 && sync_o != 2'b00) nsync++;
    end
    for (int i = 0; i < 127; i++)
      chk(rb[i] == ra[(i + 64) % 127], "R4", "rail B offset", {7'd0, rb[i]}, {7'd0, ra[(i+64)%127]});
    for (int i = 0; i < 127; i++)
      chk(ra[i] == ra[i + 127], "R5", "period", {7'd0, ra[i+127]}, {7'd0, ra[i]});
    chk(nsync == 2, "R7", "marks per period", 8'(nsync), 8'd2);
  endtask

  // R8 R9 R10 R12: word frames, mid-frame reload, resume of the sequence
  task automatic t_word();
    for (int c = 0; c < 5; c++) tick(0, 0, 16'h0, 0, 3'd1, "R12");
    tick(1, 1, 16'hB4E1, 0, 3'd1, "R9");
    for (int c = 0; c < 19; c++) tick(1, 0, 16'h0, 0, 3'd1, "R8");
    tick(1, 1, 16'h3C5A, 0, 3'd1, "R9");
    for (int c = 0; c < 10; c++) tick(1, 0, 16'hFFFF, 0, 3'd1, "R10");
    for (int c = 0; c < 20; c++) tick(0, 0, 16'h0, 0, 3'd1, "R12");
  endtask

  // R11: inject in both modes
  task automatic t_err();
    tick(0, 0, 16'h0, 0, 3'd3, "R6");
    tick(0, 0, 16'h0, 1, 3'd3, "R11");
    for (int c = 0; c < 10; c++) tick(0, 0, 16'h0, 0, 3'd3, "R11");
    tick(1, 0, 16'h0, 1, 3'd3, "R11");
    for (int c = 0; c < 9; c++) tick(1, 0, 16'h0, 0, 3'd3, "R11");
  endtask

  initial begin
    t_reset();
    t_orders();
    t_halfframe();
    t_word();
    t_err();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule